// File: doc/BRIEF.md
# Configurable Sum-of-Products Term Array with Term Allocator

This block is the programmable front end of one logic block. It takes a bus of input signals and derives a true and a complement literal from each. It evaluates a bank of programmable AND terms over those literals. The general-purpose terms are then distributed to per-macrocell OR sums under the control of a routing mask for each term. A term may be steered to one macrocell, or shared by several macrocells of the same group of four. The three last terms are not routed. They leave the block as dedicated set, reset and clock terms for the downstream registers.

Configuration is written one row per cycle through a parallel port while `cfg_en` is high. There are two row types: literal masks and routing masks. A rule checker watches the stored configuration continuously and flags two faults: a macrocell whose term count is out of range, and a term shared across groups. Every OR sum is built as the same fixed-width masked reduction, whatever the routing, so steering and sharing do not change the combinational depth to the output registers.

Top module: `pta_top`

## Requirements
- R1: Literal 2i is `din[i]` and literal 2i+1 is its complement. A term is the AND of every literal whose bit is set in that term's 72-bit literal mask.
- R2: A term whose literal mask is all zero evaluates to 1.
- R3: A term whose mask selects both literals of the same input evaluates to 0.
- R4: Macrocell sum j is the OR of the general-purpose terms 0..79 whose routing mask has bit j set. One term may drive several sums.
- R5: Term 80 drives `pt_aset`, term 81 drives `pt_areset` and term 82 drives `pt_clk`. These three terms never contribute to any macrocell sum.
- R6: `mc_sum` and the three dedicated outputs are registered. They show the effect of `din` one clock edge after it is sampled.
- R7: With `cfg_en` high, each edge writes `cfg_data` into a row. Addresses 0..82 hold the literal masks of terms 0..82. Addresses 83..162 hold the routing masks of terms 0..79 in `cfg_data[15:0]`. Writes to addresses 163 and above change nothing.
- R8: While `cfg_en` is high at an edge, all sum and dedicated outputs register 0.
- R9: `err_count` is 1 when any macrocell has 0 terms, or more than 16 terms, routed to it.
- R10: `err_share` is 1 when any term's routing mask has bits set in more than one group of four macrocells (group g = macrocells 4g..4g+3).
- R11: Synchronous active-high `rst` clears all masks and all registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration row address |
| cfg_data | input | 72 | Row data (literal mask, or routing mask in low 16 bits) |
| din | input | 36 | Logic inputs |
| mc_sum | output | 16 | Registered per-macrocell OR sums |
| pt_aset | output | 1 | Registered asynchronous-set term |
| pt_areset | output | 1 | Registered asynchronous-reset term |
| pt_clk | output | 1 | Registered product-term clock |
| err_count | output | 1 | Registered term-count rule violation |
| err_share | output | 1 | Registered cross-group sharing violation |

## Verification
The main function is tried with several input patterns. An all-zero and an all-one input word separate the true literals from the complement literals. Walking single-bit inputs show that each input reaches exactly the macrocell it was steered to and no other. Dedicated patterns isolate an empty mask, a self-contradicting mask and a term shared inside a group, so that the constant-1, constant-0 and multi-fanout cases are each seen at the sums. Further routing configurations sit just inside and just outside the count and group limits, each pushed through the configuration port, to show where each error flag switches.

// File: rtl/pta_pkg.sv
package pta_pkg;
  typedef enum logic [1:0] {
    ROW_AND   = 2'd0,
    ROW_ROUTE = 2'd1,
    ROW_NONE  = 2'd2
  } row_kind_e;
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store
  import pta_pkg::*;
#(
  parameter int N_LIT = 72,
  parameter int N_PT  = 83,
  parameter int N_GP  = 80,
  parameter int N_MC  = 16,
  parameter int AW    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_en,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [N_LIT-1:0]        cfg_data,
  output logic [N_PT*N_LIT-1:0]   and_mask_flat,
  output logic [N_GP*N_MC-1:0]    route_flat
);
  row_kind_e         kind;
  logic [N_LIT-1:0]  and_q [N_PT];
  logic [N_MC-1:0]   rt_q  [N_GP];

  always_comb begin
    if (int'(cfg_addr) < N_PT)             kind = ROW_AND;
    else if (int'(cfg_addr) < N_PT + N_GP) kind = ROW_ROUTE;
    else                                   kind = ROW_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_PT; k++) and_q[k] <= '0;
      for (int k = 0; k < N_GP; k++) rt_q[k]  <= '0;
    end else if (cfg_en) begin
      for (int k = 0; k < N_PT; k++)
        if (kind == ROW_AND && int'(cfg_addr) == k) and_q[k] <= cfg_data;
      for (int k = 0; k < N_GP; k++)
        if (kind == ROW_ROUTE && int'(cfg_addr) == k + N_PT) rt_q[k] <= cfg_data[N_MC-1:0];
    end
  end

  for (genvar k = 0; k < N_PT; k++) begin : g_and_out
    assign and_mask_flat[k*N_LIT +: N_LIT] = and_q[k];
  end
  for (genvar k = 0; k < N_GP; k++) begin : g_rt_out
    assign route_flat[k*N_MC +: N_MC] = rt_q[k];
  end
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
  parameter int N_IN = 36,
  parameter int N_PT = 83,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]        din,
  input  logic [N_PT*N_LIT-1:0]  and_mask_flat,
  output logic [N_PT-1:0]        terms
);
  logic [N_LIT-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = din[i];
    assign lit[2*i+1] = ~din[i];
  end

  // unselected literals are forced high, so an empty mask yields 1
  for (genvar k = 0; k < N_PT; k++) begin : g_term
    assign terms[k] = &(lit | ~and_mask_flat[k*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/pta_or_route.sv
module pta_or_route #(
  parameter int N_GP = 80,
  parameter int N_MC = 16
) (
  input  logic [N_GP-1:0]       gp_terms,
  input  logic [N_GP*N_MC-1:0]  route_flat,
  output logic [N_MC-1:0]       sums
);
  // every sum is the same full-width masked OR: depth is routing-independent
  for (genvar j = 0; j < N_MC; j++) begin : g_sum
    logic [N_GP-1:0] col;
    for (genvar k = 0; k < N_GP; k++) begin : g_col
      assign col[k] = route_flat[k*N_MC + j];
    end
    assign sums[j] = |(gp_terms & col);
  end
endmodule

// File: rtl/pta_rule_check.sv
module pta_rule_check #(
  parameter int N_GP   = 80,
  parameter int N_MC   = 16,
  parameter int GRP    = 4,
  parameter int MAX_PT = 16,
  localparam int N_GRP = N_MC / GRP,
  localparam int CW    = $clog2(N_GP + 1)
) (
  input  logic [N_GP*N_MC-1:0] route_flat,
  output logic                 bad_count,
  output logic                 bad_share
);
  logic [CW-1:0] cnt [N_MC];

  always_comb begin
    bad_count = 1'b0;
    for (int j = 0; j < N_MC; j++) begin
      cnt[j] = '0;
      for (int k = 0; k < N_GP; k++)
        cnt[j] = cnt[j] + CW'(route_flat[k*N_MC + j]);
      if (cnt[j] == '0 || int'(cnt[j]) > MAX_PT) bad_count = 1'b1;
    end
  end

  always_comb begin
    int touched;
    bad_share = 1'b0;
    for (int k = 0; k < N_GP; k++) begin
      touched = 0;
      for (int g = 0; g < N_GRP; g++)
        if (|route_flat[k*N_MC + g*GRP +: GRP]) touched++;
      if (touched > 1) bad_share = 1'b1;
    end
  end
endmodule

// File: rtl/pta_top.sv
module pta_top #(
  parameter int N_IN   = 36,
  parameter int N_PT   = 83,
  parameter int N_MC   = 16,
  parameter int GRP    = 4,
  parameter int MAX_PT = 16,
  localparam int N_LIT = 2 * N_IN,
  localparam int N_GP  = N_PT - 3,
  localparam int AW    = $clog2(N_PT + N_GP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [N_LIT-1:0] cfg_data,
  input  logic [N_IN-1:0]  din,
  output logic [N_MC-1:0]  mc_sum,
  output logic             pt_aset,
  output logic             pt_areset,
  output logic             pt_clk,
  output logic             err_count,
  output logic             err_share
);
  logic [N_PT*N_LIT-1:0] and_mask_flat;
  logic [N_GP*N_MC-1:0]  route_flat;
  logic [N_PT-1:0]       terms;
  logic [N_GP-1:0]       gp_terms;
  logic [N_MC-1:0]       sums;
  logic                  bad_count, bad_share;

  pta_cfg_store #(.N_LIT(N_LIT), .N_PT(N_PT), .N_GP(N_GP), .N_MC(N_MC), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .and_mask_flat(and_mask_flat), .route_flat(route_flat)
  );

  pta_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .din(din), .and_mask_flat(and_mask_flat), .terms(terms)
  );

  assign gp_terms = terms[N_GP-1:0];

  pta_or_route #(.N_GP(N_GP), .N_MC(N_MC)) u_or (
    .gp_terms(gp_terms), .route_flat(route_flat), .sums(sums)
  );

  pta_rule_check #(.N_GP(N_GP), .N_MC(N_MC), .GRP(GRP), .MAX_PT(MAX_PT)) u_chk (
    .route_flat(route_flat), .bad_count(bad_count), .bad_share(bad_share)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_en) begin
      mc_sum    <= '0;
      pt_aset   <= 1'b0;
      pt_areset <= 1'b0;
      pt_clk    <= 1'b0;
    end else begin
      mc_sum    <= sums;
      pt_aset   <= terms[N_GP];
      pt_areset <= terms[N_GP+1];
      pt_clk    <= terms[N_GP+2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_count <= 1'b0;
      err_share <= 1'b0;
    end else begin
      err_count <= bad_count;
      err_share <= bad_share;
    end
  end
endmodule

// File: rtl/pta_checker.sv
module pta_checker #(
  parameter int N_MC = 16,
  parameter int N_GP = 80
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_en,
  input logic [N_MC-1:0] mc_sum,
  input logic            pt_aset,
  input logic            pt_areset,
  input logic            pt_clk,
  input logic            err_count,
  input logic            err_share,
  input logic [N_GP-1:0] gp_terms
);
  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> (mc_sum == '0 && !pt_aset && !pt_areset && !pt_clk));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (mc_sum == '0 && !pt_aset && !pt_areset && !pt_clk && !err_count && !err_share));

  p_no_source_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && gp_terms == '0) |=> (mc_sum == '0));

  p_err_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !$past(cfg_en) && !$past(rst)) |=> $stable({err_count, err_share}));
endmodule

bind pta_top pta_checker #(.N_MC(N_MC), .N_GP(N_GP)) chk_i (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .mc_sum(mc_sum),
  .pt_aset(pt_aset), .pt_areset(pt_areset), .pt_clk(pt_clk),
  .err_count(err_count), .err_share(err_share), .gp_terms(gp_terms)
);

// File: tb/pta_top_tb_top.sv
`timescale 1ns/1ps
module pta_top_tb_top;
  localparam int N_IN = 36;
  localparam int N_PT = 83;
  localparam int N_MC = 16;
  localparam int N_LIT = 2 * N_IN;
  localparam int N_GP = N_PT - 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [N_LIT-1:0] cfg_data = '0;
  logic [N_IN-1:0] din = '0;
  logic [N_MC-1:0] mc_sum;
  logic pt_aset, pt_areset, pt_clk, err_count, err_share;

  int n_chk = 0;
  int n_bad = 0;

  logic [N_LIT-1:0] m_and [N_PT];
  logic [N_MC-1:0]  m_rt  [N_GP];

  always #5 clk = ~clk;

  pta_top dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .din(din), .mc_sum(mc_sum), .pt_aset(pt_aset), .pt_areset(pt_areset),
    .pt_clk(pt_clk), .err_count(err_count), .err_share(err_share)
  );

  function automatic logic term_val(int k, logic [N_IN-1:0] d);
    for (int i = 0; i < N_IN; i++) begin
      if (m_and[k][2*i] && !d[i]) return 1'b0;
      if (m_and[k][2*i+1] && d[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [N_MC-1:0] exp_sum(logic [N_IN-1:0] d);
    logic [N_MC-1:0] s = '0;
    for (int k = 0; k < N_GP; k++)
      if (term_val(k, d)) s |= m_rt[k];
    return s;
  endfunction

  function automatic logic exp_cnt_err();
    for (int j = 0; j < N_MC; j++) begin
      int c = 0;
      for (int k = 0; k < N_GP; k++) c += int'(m_rt[k][j]);
      if (c == 0 || c > 16) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic exp_share_err();
    for (int k = 0; k < N_GP; k++) begin
      int t = 0;
      for (int g = 0; g < N_MC / 4; g++) if (|m_rt[k][g*4 +: 4]) t++;
      if (t > 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(int addr, logic [N_LIT-1:0] data);
    @(negedge clk);
    cfg_en = 1'b1; cfg_addr = 8'(addr); cfg_data = data;
    if (addr < N_PT) m_and[addr] = data;
    else if (addr < N_PT + N_GP) m_rt[addr - N_PT] = data[N_MC-1:0];
    @(posedge clk); #1;
    cfg_en = 1'b0;
  endtask

  task automatic apply_check(string req, logic [N_IN-1:0] d);
    @(negedge clk);
    cfg_en = 1'b0; din = d;
    step();
    cmp(req, "mc_sum", 32'(mc_sum), 32'(exp_sum(d)));
    cmp(req, "dedicated", {29'd0, pt_aset, pt_areset, pt_clk},
        {29'd0, term_val(N_GP, d), term_val(N_GP+1, d), term_val(N_GP+2, d)});
    cmp(req, "errors", {30'd0, err_count, err_share}, {30'd0, exp_cnt_err(), exp_share_err()});
  endtask

  task automatic t_reset();
    for (int k = 0; k < N_PT; k++) m_and[k] = '0;
    for (int k = 0; k < N_GP; k++) m_rt[k] = '0;
    rst = 1'b1;
    repeat (3) step();
    cmp("R11", "outputs in reset", {mc_sum, pt_aset, pt_areset, pt_clk, err_count, err_share}, '0);
    @(negedge clk); rst = 1'b0;
    step();
    // R2: empty masks give 1 on dedicated terms; R9: all counts are zero
    cmp("R2", "dedicated after reset", {29'd0, pt_aset, pt_areset, pt_clk}, 32'd7);
    cmp("R9", "err_count after reset", 32'(err_count), 32'd1);
    cmp("R4", "mc_sum with no routing", 32'(mc_sum), 32'd0);
  endtask

  task automatic t_base();
    // term k uses true literal of input k%36; terms 5j..5j+4 go to macrocell j
    for (int k = 0; k < N_GP; k++) begin
      wr(k, N_LIT'(1) << (2 * (k % N_IN)));
      wr(N_PT + k, N_LIT'(1) << (k / 5));
    end
    wr(N_GP,     N_LIT'(1) << 0);               // aset = din[0]
    wr(N_GP + 1, N_LIT'(1) << 3);               // areset = ~din[1]
    wr(N_GP + 2, (N_LIT'(1) << 4) | (N_LIT'(1) << 6)); // clk = din[2]&din[3]
    apply_check("R1", '0);
    apply_check("R1", '1);
    cmp("R9", "no count error", 32'(err_count), 32'd0);
    cmp("R10", "no share error", 32'(err_share), 32'd0);
    for (int i = 0; i < N_IN; i += 7) apply_check("R4", N_IN'(1) << i);
    apply_check("R5", 36'h00000000C);
    apply_check("R5", 36'h000000003);
  endtask

  task automatic t_latency();
    apply_check("R6", '0);
    @(negedge clk); din = '1; #1;
    cmp("R6", "no change before edge", 32'(mc_sum), 32'd0);
    step();
    cmp("R6", "after edge", 32'(mc_sum), 32'hFFFF);
  endtask

  task automatic t_polarity();
    wr(0, 72'h3);               // term 0: din[0] & ~din[0]
    apply_check("R3", 36'h1);
    cmp("R3", "contradiction gives 0", 32'(mc_sum[0]), 32'd0);
    wr(5, '0);                  // term 5 empty -> 1, feeds mc1
    apply_check("R2", '0);
    cmp("R2", "empty term drives mc1", 32'(mc_sum[1]), 32'd1);
    wr(0, 72'h1);
    wr(5, N_LIT'(1) << 10);
  endtask

  task automatic t_share();
    wr(N_PT + 0, 72'h9);        // term 0 -> mc0 and mc3, same group
    apply_check("R10", 36'h1);
    cmp("R4", "shared term reaches mc3", 32'(mc_sum & 16'h0009), 32'h9);
    wr(N_PT + 0, 72'h11);       // mc0 and mc4: two groups
    step();
    cmp("R10", "cross-group flagged", 32'(err_share), 32'd1);
    wr(N_PT + 0, 72'h1);
    step();
    cmp("R10", "cleared", 32'(err_share), 32'd0);
  endtask

  task automatic t_count();
    // move terms 15..19 (mc3) to mc2: mc3 has 0, mc2 has 10
    for (int k = 15; k < 20; k++) wr(N_PT + k, 72'h4);
    step();
    cmp("R9", "zero terms flagged", 32'(err_count), 32'd1);
    // give mc3 terms 20..35 (16 terms) -> mc4..mc7 drop; restore mc2 terms first
    for (int k = 15; k < 20; k++) wr(N_PT + k, 72'h8);
    for (int k = 20; k < 36; k++) wr(N_PT + k, 72'h8);
    // mc3 now 21, mc4..6 zero -> error
    step();
    cmp("R9", "over limit flagged", 32'(err_count), 32'd1);
    // give mc3 exactly 16: terms 15..19 plus 20..30; rest of mc4..7 via 31..39 and spare
    for (int k = 31; k < 36; k++) wr(N_PT + k, N_LIT'(1) << (4 + (k - 31) % 4));
    for (int k = 36; k < 40; k++) wr(N_PT + k, N_LIT'(1) << (4 + (k - 36)));
    apply_check("R9", 36'h0F0F0F0F0);
    cmp("R9", "sixteen accepted", 32'(err_count), 32'd0);
  endtask

  task automatic t_cfg_port();
    @(negedge clk);
    din = '1; cfg_en = 1'b1; cfg_addr = 8'd200; cfg_data = '0;
    step();
    cmp("R8", "quiet while configuring", {mc_sum, pt_aset, pt_areset, pt_clk}, '0);
    step();
    cmp("R8", "still quiet", 32'(mc_sum), 32'd0);
    apply_check("R7", '1);
    apply_check("R7", 36'h5A5A5A5A5);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_base();
    t_latency();
    t_polarity();
    t_share();
    t_count();
    t_cfg_port();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule